// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a bank of 32-bit control and status registers behind a plain word-addressed read/write port with a 4 KB window. A magic key written to a lock register unlocks the bank. While it is unlocked, a write to the reset-control register stores a value and sends out a one-cycle reset request. A relocked bank ignores such writes. Two flag words, one volatile and one non-volatile, are each changed through a pair of addresses. One address ORs bits in and the other clears them. Reading the set address returns the current word.

A constant identification word is a parameter. Its variant field selects how the display-control register behaves. On the earliest variant, bits 13:8 are read-only and a write also drives a 2-bit mux-select output. Two later variants let only bit 7 change. The newest variant has no display-control register. A read-only counter advances at a 24 MHz average rate, derived from the bank clock by a fractional accumulator.

The port has no back-pressure. Every access is taken in the cycle it is presented. Read data is registered: it shows the addressed word one cycle after `rd_en` and holds until the next read. Word offsets are: 0x00 identification, 0x04 lock, 0x08 reset control, 0x0C flag set/read, 0x10 flag clear, 0x14 non-volatile flag set/read, 0x18 non-volatile flag clear, 0x1C display control, 0x20 tick counter.

Top module: `sysctl_bank`

## Requirements
- R1: After reset the lock reads 0x0001_0000, both flag words read 0, display control reads 0x1F00 (0 on the newest variant), and `rst_req` and `mux_sel` are 0.
- R2: Writing exactly 0x0000_A05F to the lock offset unlocks the bank. The lock then reads 0x0000_205F: bits 14:0 hold the stored value and bit 16, the locked flag, is 0.
- R3: Writing any other value to the lock offset stores only its low 15 bits and leaves the bank locked, so bit 16 reads 1. For example, 0x0001_A05F reads back as 0x0001_205F.
- R4: A write to reset control while unlocked stores its low 8 bits and raises `rst_req` for exactly one cycle after the write edge. While locked, the write changes nothing and `rst_req` stays 0.
- R5: A write to the flag set offset ORs the data into the flag word, and a write to the flag clear offset clears the bits set in the data. Reading the set offset returns the word, and reading either clear offset returns 0.
- R6: The non-volatile flag word has its own set and clear offsets, and it does not affect the volatile word or take effect from it.
- R7: Variants other than 0x178, 0x182 and 0x190 keep display bits 13:8 and write all other bits. On variant 0x100 only, each display write also loads data bits 1:0 into `mux_sel`. `mux_sel` changes on no other event.
- R8: On variants 0x178 and 0x182, a display write changes bit 7 alone, and `mux_sel` stays 0.
- R9: On variant 0x190, display control always reads 0 and ignores writes.
- R10: The identification offset returns the `ID_WORD` parameter, whose bits 27:16 are the variant, and ignores writes.
- R11: The tick counter gains exactly 24 counts in every 100 consecutive cycles at the default 100 MHz / 24 MHz setting, and a write to it has no effect.
- R12: Undefined offsets read 0 and ignore writes, with no error. Address bits 1:0 are ignored. `rdata` changes only one cycle after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| addr | input | 12 | Byte address in the 4 KB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle reset request pulse |
| mux_sel | output | 2 | Display mux select |

## Verification
The bench attacks the lock key edge: a value that matches the key in its low 16 bits but has a higher bit set. A design that compared only 16 bits would unlock there and then accept a reset write that must be refused. Set and clear words with overlapping bits catch a clear that ANDs instead of masking out, and the clear-address reads catch a decoder that aliases them onto the flag word. Three variants are driven from one shared port. A wrong mask shows up as a changed read-only field or a lost bit 7, and a `mux_sel` that moves off variant 0x100. The tick delta, measured over exact 100-cycle windows with a write in between, catches a counter that can be written or that divides at the wrong rate.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned WIDX_W = ADDR_W - 2;

  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

  // word indices inside the window
  localparam logic [WIDX_W-1:0] W_ID       = WIDX_W'(0);
  localparam logic [WIDX_W-1:0] W_LOCK     = WIDX_W'(1);
  localparam logic [WIDX_W-1:0] W_RST      = WIDX_W'(2);
  localparam logic [WIDX_W-1:0] W_FLAG     = WIDX_W'(3);
  localparam logic [WIDX_W-1:0] W_FLAG_CLR = WIDX_W'(4);
  localparam logic [WIDX_W-1:0] W_NVF      = WIDX_W'(5);
  localparam logic [WIDX_W-1:0] W_NVF_CLR  = WIDX_W'(6);
  localparam logic [WIDX_W-1:0] W_DISP     = WIDX_W'(7);
  localparam logic [WIDX_W-1:0] W_TICK     = WIDX_W'(8);

  localparam logic [11:0] VAR_FIRST = 12'h100;
  localparam logic [11:0] VAR_NEWEST = 12'h190;

  typedef enum logic [1:0] {
    DK_WIDE,
    DK_BIT7,
    DK_ABSENT
  } disp_kind_e;

  function automatic disp_kind_e disp_kind(input logic [11:0] variant);
    case (variant)
      12'h178, 12'h182: return DK_BIT7;
      VAR_NEWEST:       return DK_ABSENT;
      default:          return DK_WIDE;
    endcase
  endfunction

  // bits that a write leaves untouched
  function automatic logic [31:0] disp_keep(input disp_kind_e kind);
    case (kind)
      DK_BIT7:   return ~32'h0000_0080;
      DK_ABSENT: return 32'hFFFF_FFFF;
      default:   return 32'h0000_3F00;
    endcase
  endfunction

  function automatic logic [31:0] disp_init(input disp_kind_e kind);
    return (kind == DK_ABSENT) ? 32'h0 : 32'h0000_1F00;
  endfunction

endpackage

// File: rtl/sctl_lock_unit.sv
module sctl_lock_unit
  import sctl_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned RST_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_we,
  input  logic             ctl_we,
  input  logic [DW-1:0]    wdata,
  output logic [14:0]      lock_low,
  output logic             unlocked,
  output logic [RST_W-1:0] rst_ctl,
  output logic             rst_req
);

  logic [15:0] lock_q;
  logic        key_hit;

  assign key_hit  = (wdata == DW'(UNLOCK_KEY));
  assign unlocked = (lock_q == UNLOCK_KEY);
  assign lock_low = lock_q[14:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
    end else if (lock_we) begin
      lock_q <= key_hit ? UNLOCK_KEY : {1'b0, wdata[14:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_ctl <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (ctl_we && unlocked) begin
        rst_ctl <= wdata[RST_W-1:0];
        rst_req <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sctl_flag_pair.sv
module sctl_flag_pair #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (set_we) begin
      word <= word | wdata;
    end else if (clr_we) begin
      word <= word & ~wdata;
    end
  end

endmodule

// File: rtl/sctl_disp_reg.sv
module sctl_disp_reg
  import sctl_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter logic [11:0] VARIANT = 12'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] disp,
  output logic [1:0]    mux_sel
);

  localparam disp_kind_e    KIND = disp_kind(VARIANT);
  localparam logic [DW-1:0] KEEP = DW'(disp_keep(KIND));
  localparam logic [DW-1:0] INIT = DW'(disp_init(KIND));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp <= INIT;
    end else if (we) begin
      disp <= (disp & KEEP) | (wdata & ~KEEP);
    end
  end

  generate
    if (VARIANT == VAR_FIRST) begin : g_mux
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mux_sel <= '0;
        end else if (we) begin
          mux_sel <= wdata[1:0];
        end
      end
    end else begin : g_nomux
      assign mux_sel = '0;
    end
  endgenerate

endmodule

// File: rtl/sctl_tick_gen.sv
module sctl_tick_gen #(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned TICK_HZ = 24_000_000,
  parameter int unsigned CW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] count
);

  localparam int unsigned ACC_W = $clog2(CLK_HZ + TICK_HZ) + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;
  logic             wrap;

  assign acc_sum = acc_q + ACC_W'(TICK_HZ);
  assign wrap    = (acc_sum >= ACC_W'(CLK_HZ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      count <= '0;
    end else if (wrap) begin
      acc_q <= acc_sum - ACC_W'(CLK_HZ);
      count <= count + 1'b1;
    end else begin
      acc_q <= acc_sum;
    end
  end

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sctl_pkg::*;
#(
  parameter logic [31:0] ID_WORD = 32'h3100_0A2C,
  parameter int unsigned RST_W   = 8,
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned TICK_HZ = 24_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_req,
  output logic [1:0]        mux_sel
);

  localparam logic [11:0] VARIANT = ID_WORD[27:16];

  logic [WIDX_W-1:0] widx;
  logic [1:0]        unused_lsb;
  logic [14:0]       lock_low;
  logic              unlocked;
  logic [RST_W-1:0]  rst_ctl;
  logic [DATA_W-1:0] flag_word;
  logic [DATA_W-1:0] nvflag_word;
  logic [DATA_W-1:0] disp;
  logic [DATA_W-1:0] tick;
  logic [DATA_W-1:0] rd_mux;

  assign widx       = addr[ADDR_W-1:2];
  assign unused_lsb = addr[1:0];

  sctl_lock_unit #(.DW(DATA_W), .RST_W(RST_W)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_we  (wr_en && widx == W_LOCK),
    .ctl_we   (wr_en && widx == W_RST),
    .wdata    (wdata),
    .lock_low (lock_low),
    .unlocked (unlocked),
    .rst_ctl  (rst_ctl),
    .rst_req  (rst_req)
  );

  sctl_flag_pair #(.DW(DATA_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (wr_en && widx == W_FLAG),
    .clr_we (wr_en && widx == W_FLAG_CLR),
    .wdata  (wdata),
    .word   (flag_word)
  );

  sctl_flag_pair #(.DW(DATA_W)) u_nvflags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (wr_en && widx == W_NVF),
    .clr_we (wr_en && widx == W_NVF_CLR),
    .wdata  (wdata),
    .word   (nvflag_word)
  );

  sctl_disp_reg #(.DW(DATA_W), .VARIANT(VARIANT)) u_disp (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_en && widx == W_DISP),
    .wdata   (wdata),
    .disp    (disp),
    .mux_sel (mux_sel)
  );

  sctl_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CW(DATA_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .count (tick)
  );

  always_comb begin
    case (widx)
      W_ID:    rd_mux = ID_WORD;
      W_LOCK:  rd_mux = {15'b0, ~unlocked, 1'b0, lock_low};
      W_RST:   rd_mux = DATA_W'(rst_ctl);
      W_FLAG:  rd_mux = flag_word;
      W_NVF:   rd_mux = nvflag_word;
      W_DISP:  rd_mux = disp;
      W_TICK:  rd_mux = tick;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk
  import sctl_pkg::*;
#(
  parameter logic [31:0] ID_WORD = 32'h3100_0A2C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [WIDX_W-1:0] widx,
  input logic [DATA_W-1:0] rdata,
  input logic              rst_req,
  input logic [1:0]        mux_sel,
  input logic              unlocked
);

  localparam logic [11:0] VARIANT = ID_WORD[27:16];

  AST_RST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R4

  AST_RST_FROM_UNLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(wr_en && widx == W_RST && unlocked)); // R4

  AST_LOCKED_BLOCKS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == W_RST && !unlocked) |=> !rst_req); // R4

  AST_MUX_ONLY_ON_DISP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && widx == W_DISP) |=> $stable(mux_sel)); // R7

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R12

  AST_UNDEF_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && widx > W_TICK) |=> rdata == '0); // R12

  generate
    if (VARIANT == VAR_NEWEST) begin : g_newest
      AST_NEWEST_DISP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && widx == W_DISP) |=> rdata == '0); // R9
    end
  endgenerate

endmodule

bind sysctl_bank sysctl_bank_chk #(.ID_WORD(ID_WORD)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .widx     (widx),
  .rdata    (rdata),
  .rst_req  (rst_req),
  .mux_sel  (mux_sel),
  .unlocked (unlocked)
);

// File: tb/sysctl_bank_tb_top.sv
module sysctl_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;

  logic [31:0] rdata_a, rdata_b, rdata_c;
  logic        rreq_a, rreq_b, rreq_c;
  logic [1:0]  mux_a, mux_b, mux_c;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // variant 0x100 (earliest)
  sysctl_bank #(.ID_WORD(32'h3100_0A2C)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_a), .rst_req(rreq_a), .mux_sel(mux_a));

  // variant 0x178 (bit 7 only)
  sysctl_bank #(.ID_WORD(32'h0178_0000)) dut_b7 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_b), .rst_req(rreq_b), .mux_sel(mux_b));

  // variant 0x190 (no display register)
  sysctl_bank #(.ID_WORD(32'h0190_0000)) dut_new (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_c), .rst_req(rreq_c), .mux_sel(mux_c));

  typedef struct packed {
    logic        wr;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] e;
    logic [7:0]  r;
  } vec_t;

  localparam int VEC_N = 29;
  localparam vec_t VEC [VEC_N] = '{
    '{1'b0, 12'h000, 32'h0,         32'h3100_0A2C, 8'd10}, // R10 id
    '{1'b0, 12'h004, 32'h0,         32'h0001_0000, 8'd1},  // R1 lock
    '{1'b0, 12'h00C, 32'h0,         32'h0,         8'd1},  // R1 flags
    '{1'b0, 12'h01C, 32'h0,         32'h0000_1F00, 8'd1},  // R1 display
    '{1'b1, 12'h00C, 32'h0000_00F0, 32'h0,         8'd5},
    '{1'b1, 12'h00C, 32'h0F00_0001, 32'h0,         8'd5},
    '{1'b0, 12'h00C, 32'h0,         32'h0F00_00F1, 8'd5},  // R5 set ORs
    '{1'b1, 12'h010, 32'h0000_0031, 32'h0,         8'd5},
    '{1'b0, 12'h00C, 32'h0,         32'h0F00_00C0, 8'd5},  // R5 clear
    '{1'b0, 12'h010, 32'h0,         32'h0,         8'd5},  // R5 clear addr reads 0
    '{1'b1, 12'h014, 32'h8000_0000, 32'h0,         8'd6},
    '{1'b1, 12'h014, 32'h0000_0003, 32'h0,         8'd6},
    '{1'b1, 12'h018, 32'h0000_0001, 32'h0,         8'd6},
    '{1'b0, 12'h014, 32'h0,         32'h8000_0002, 8'd6},  // R6 nv word
    '{1'b0, 12'h00C, 32'h0,         32'h0F00_00C0, 8'd6},  // R6 independent
    '{1'b1, 12'h004, 32'h1234_F0F0, 32'h0,         8'd3},
    '{1'b0, 12'h004, 32'h0,         32'h0001_70F0, 8'd3},  // R3 low 15 bits
    '{1'b1, 12'h004, 32'h0001_A05F, 32'h0,         8'd3},
    '{1'b0, 12'h004, 32'h0,         32'h0001_205F, 8'd3},  // R3 near-key stays locked
    '{1'b1, 12'h01C, 32'h0000_00FE, 32'h0,         8'd7},
    '{1'b0, 12'h01C, 32'h0,         32'h0000_1FFE, 8'd7},  // R7 writable bits
    '{1'b1, 12'h01C, 32'h0000_2A01, 32'h0,         8'd7},
    '{1'b0, 12'h01C, 32'h0,         32'h0000_1F01, 8'd7},  // R7 13:8 read-only
    '{1'b0, 12'h100, 32'h0,         32'h0,         8'd12}, // R12 undefined
    '{1'b1, 12'h100, 32'hFFFF_FFFF, 32'h0,         8'd12},
    '{1'b0, 12'hFFC, 32'h0,         32'h0,         8'd12}, // R12 top of window
    '{1'b0, 12'h00E, 32'h0,         32'h0F00_00C0, 8'd12}, // R12 lsb ignored
    '{1'b1, 12'h000, 32'h0,         32'h0,         8'd10},
    '{1'b0, 12'h000, 32'h0,         32'h3100_0A2C, 8'd10}  // R10 write ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", checks, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 rst_req after reset", 32'(rreq_a), 32'h0);
    check("R1 mux_sel after reset", 32'(mux_a), 32'h0);
    bus_read(12'h01C);
    check("R9 newest display reset", rdata_c, 32'h0);

    for (int i = 0; i < VEC_N; i++) begin
      if (VEC[i].wr) begin
        bus_write(VEC[i].a, VEC[i].d);
      end else begin
        bus_read(VEC[i].a);
        check($sformatf("R%0d vector %0d", VEC[i].r, i), rdata_a, VEC[i].e);
      end
    end

    check("R7 mux after write 0x2A01", 32'(mux_a), 32'h1);
    bus_read(12'h01C);
    check("R8 bit7 display after writes", rdata_b, 32'h0000_1F00);
    bus_write(12'h01C, 32'hFFFF_FFFF);
    check("R7 mux after all-ones write", 32'(mux_a), 32'h3);
    check("R8 bit7 variant mux stays 0", 32'(mux_b), 32'h0);
    bus_read(12'h01C);
    check("R7 display all-ones", rdata_a, 32'hFFFF_DFFF);
    check("R8 bit7 display all-ones", rdata_b, 32'h0000_1F80);
    check("R9 newest display ignores write", rdata_c, 32'h0);

    // reset control, currently locked
    bus_write(12'h008, 32'h0000_0055);
    check("R4 locked write no pulse", 32'(rreq_a), 32'h0);
    bus_read(12'h008);
    check("R4 locked write not stored", rdata_a, 32'h0);
    bus_write(12'h004, 32'h0000_A05F);
    bus_read(12'h004);
    check("R2 unlocked lock value", rdata_a, 32'h0000_205F);
    bus_write(12'h008, 32'h0000_01A5);
    check("R4 pulse after unlocked write", 32'(rreq_a), 32'h1);
    @(negedge clk);
    check("R4 pulse lasts one cycle", 32'(rreq_a), 32'h0);
    bus_read(12'h008);
    check("R4 stored low 8 bits", rdata_a, 32'h0000_00A5);
    bus_write(12'h004, 32'h0);
    bus_read(12'h004);
    check("R3 relocked", rdata_a, 32'h0001_0000);
    bus_write(12'h008, 32'h0000_0033);
    check("R4 relocked no pulse", 32'(rreq_a), 32'h0);
    bus_read(12'h008);
    check("R4 relocked keeps value", rdata_a, 32'h0000_00A5);

    // tick counter: 100-cycle windows
    bus_read(12'h020);
    t0 = rdata_a;
    repeat (99) @(negedge clk);
    bus_read(12'h020);
    check("R11 tick delta 100 cycles", rdata_a - t0, 32'd24);
    t0 = rdata_a;
    bus_write(12'h020, 32'h0);
    repeat (98) @(negedge clk);
    bus_read(12'h020);
    check("R11 tick write ignored", rdata_a - t0, 32'd24);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule